// File: doc/BRIEF.md
# Pin-Mask Serial Byte Shifter

This block sends bytes one bit at a time over two pins of a shared 8-bit output port. It can, for instance, stream a configuration image into an attached programmable device. A configuration word names the pins. Its low byte is a mask for the clock pin and its second byte is a mask for the data pin. Bit 16 of the word picks the bit order. The block checks the masks against the writable-bit mask and the output-direction mask supplied by the port. It refuses any configuration whose pins cannot legally be driven.

Bytes arrive over a valid/ready handshake. For each bit the block pulls the clock pin low, then drives the data pin, and then waits a programmable number of setup cycles. After that it raises the clock and holds it high. The port image it presents matches the incoming shadow value on every pin outside the two masks. Only the clock and data pins are overridden.

Top module: `pin_shifter`

## Requirements
- R1: A configuration write (`cfg_wr` in an idle cycle) is accepted when both the clock mask (`cfg_word[7:0]`) and the data mask (`cfg_word[15:8]`) share at least one bit with `wr_ok_mask` and at least one bit with `out_dir`. Acceptance loads both masks and clears `cfg_err` on the next edge.
- R2: A refused configuration clears both masks and sets `cfg_err` to 1. `cfg_err` stays 1 until a later configuration is accepted, and while it is 1 both masks are zero.
- R3: A byte offered while either mask is zero is consumed (`in_ready` stays 1). It produces a one-cycle `wr_err` pulse in the cycle after acceptance and causes no clock edge on any pin.
- R4: Each bit takes the following steps in order. The clock pins go low for one cycle. Then the data pins take the bit value for `SETUP_CYC` cycles with the clock still low. Then the clock pins are high for `HIGH_CYC` cycles. A byte is exactly 8 such periods of 1+`SETUP_CYC`+`HIGH_CYC` cycles.
- R5: `cfg_word[16]`=1 sends bit 7 first and =0 sends bit 0 first. The order is captured with the configuration.
- R6: On every port bit outside the two masks, `port_out` equals `shadow_in` at all times.
- R7: `in_ready` is low from the cycle after a byte is accepted until the last bit's clock-high phase has lasted `HIGH_CYC` cycles. It is high again 8 bit periods after acceptance.
- R8: The clock level is high after reset and whenever the block is idle, including after every transfer.
- R9: `cfg_wr` during a transfer is ignored. The masks and the bit order in use do not change.
- R10: When `cfg_wr` and `in_valid` arrive in the same idle cycle, the configuration wins. `in_ready` is low in that cycle, and the byte is taken later under the new configuration.
- R11: After reset, `in_ready` is 1, `cfg_err` and `wr_err` are 0, and both masks are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 17 | Clock mask [7:0], data mask [15:8], MSB-first flag [16] |
| wr_ok_mask | input | 8 | Port bits that may be written |
| out_dir | input | 8 | Port bits currently set as outputs |
| shadow_in | input | 8 | Current port shadow value |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can take a byte |
| port_out | output | 8 | Port value with clock and data pins overridden |
| cfg_err | output | 1 | Last configuration was refused |
| wr_err | output | 1 | One-cycle pulse: byte refused for lack of masks |

## Verification
A configuration write and a byte offer can land on the same idle cycle. If the byte were taken under the old masks, the masks would then change in the middle of the transfer. The bench raises `cfg_wr` and `in_valid` together on one edge. It judges the outcome in two ways: `in_ready` must read low in that cycle, and the bits captured on the pins of the new configuration must match the byte. A second case issues a configuration write in the middle of a byte and checks that both that byte and the following one still appear on the old pins.

// File: rtl/pin_shifter.sv
module pin_shifter #(
  parameter int W         = 8,
  parameter int NB        = 8,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2*W:0]  cfg_word,
  input  logic [W-1:0]  wr_ok_mask,
  input  logic [W-1:0]  out_dir,
  input  logic [W-1:0]  shadow_in,
  input  logic          in_valid,
  input  logic [NB-1:0] in_data,
  output logic          in_ready,
  output logic [W-1:0]  port_out,
  output logic          cfg_err,
  output logic          wr_err
);
  localparam int MAXC = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(NB);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_SU, S_HI} st_t;
  st_t st;

  logic [W-1:0]  cm, dm;
  logic          msb;
  logic          clk_lvl, dat_lvl;
  logic [NB-1:0] sreg;
  logic [BW-1:0] bcnt;
  logic [CW-1:0] cnt;

  wire [W-1:0] cw_clk = cfg_word[W-1:0];
  wire [W-1:0] cw_dat = cfg_word[2*W-1:W];
  wire cfg_ok = (|(cw_clk & wr_ok_mask)) && (|(cw_dat & wr_ok_mask)) &&
                (|(cw_clk & out_dir))    && (|(cw_dat & out_dir));
  wire idle   = (st == S_IDLE);
  wire busy   = !idle;
  wire armed  = (|cm) && (|dm);
  wire cur_bit = msb ? sreg[NB-1] : sreg[0];

  assign in_ready = idle && !cfg_wr;
  assign port_out = (shadow_in & ~(cm | dm)) | ({W{clk_lvl}} & cm) | ({W{dat_lvl}} & dm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cm      <= '0;
      dm      <= '0;
      msb     <= 1'b0;
      cfg_err <= 1'b0;
      wr_err  <= 1'b0;
      clk_lvl <= 1'b1;
      dat_lvl <= 1'b0;
      sreg    <= '0;
      bcnt    <= '0;
      cnt     <= '0;
    end else begin
      wr_err <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (cfg_wr) begin
            msb <= cfg_word[2*W];
            if (cfg_ok) begin
              cm      <= cw_clk;
              dm      <= cw_dat;
              cfg_err <= 1'b0;
            end else begin
              cm      <= '0;
              dm      <= '0;
              cfg_err <= 1'b1;
            end
          end else if (in_valid) begin
            if (armed) begin
              sreg    <= in_data;
              bcnt    <= '0;
              clk_lvl <= 1'b0;
              st      <= S_LO;
            end else begin
              wr_err <= 1'b1;
            end
          end
        end
        S_LO: begin
          dat_lvl <= cur_bit;
          cnt     <= CW'(SETUP_CYC - 1);
          st      <= S_SU;
        end
        S_SU: begin
          if (cnt == '0) begin
            clk_lvl <= 1'b1;
            cnt     <= CW'(HIGH_CYC - 1);
            st      <= S_HI;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HI: begin
          if (cnt == '0) begin
            if (bcnt == BW'(NB - 1)) begin
              st <= S_IDLE;
            end else begin
              clk_lvl <= 1'b0;
              bcnt    <= bcnt + 1'b1;
              sreg    <= msb ? (sreg << 1) : (sreg >> 1);
              st      <= S_LO;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pin_shifter_chk.sv
module pin_shifter_chk #(
  parameter int W         = 8,
  parameter int SETUP_CYC = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         wr_err,
  input logic         cfg_err,
  input logic         busy,
  input logic         clk_lvl,
  input logic         dat_lvl,
  input logic [W-1:0] cm,
  input logic [W-1:0] dm
);
  logic        dat_q;
  logic [15:0] stab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q <= 1'b0;
      stab  <= '0;
    end else begin
      dat_q <= dat_lvl;
      if (dat_lvl != dat_q) stab <= 16'd1;
      else if (stab != 16'hFFFF) stab <= stab + 1'b1;
    end
  end

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (cm != '0) && (dm != '0)) |=> !in_ready);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cm) && $stable(dm)));

  // R3
  wr_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(in_valid && in_ready && ((cm == '0) || (dm == '0))));

  // R8
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> clk_lvl);

  // R4
  setup_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_lvl) |-> (stab >= 16'(SETUP_CYC)));

  // R2
  err_masks_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ((cm == '0) && (dm == '0)));
endmodule

bind pin_shifter pin_shifter_chk #(.W(W), .SETUP_CYC(SETUP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_err(wr_err), .cfg_err(cfg_err), .busy(busy), .clk_lvl(clk_lvl),
  .dat_lvl(dat_lvl), .cm(cm), .dm(dm)
);

// File: tb/sim_pin_shifter.sv
`timescale 1ns/1ps
module sim_pin_shifter;
  localparam int P = 1 + 2 + 2;
  localparam int BYTE_CYC = 8 * P + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [16:0] cfg_word = '0;
  logic [7:0] wr_ok_mask = 8'hFF, out_dir = 8'hFF, shadow_in = 8'h00;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, cfg_err, wr_err;
  logic [7:0] port_out;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  pin_shifter #(.W(8), .NB(8), .SETUP_CYC(2), .HIGH_CYC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .wr_ok_mask(wr_ok_mask), .out_dir(out_dir), .shadow_in(shadow_in),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .port_out(port_out), .cfg_err(cfg_err), .wr_err(wr_err)
  );

  // {shadow, byte, cfg[31:0]}
  localparam logic [47:0] VEC [4] = '{
    {8'hF0, 8'hA5, 32'h0001_0201},
    {8'h55, 8'h3C, 32'h0000_0880},
    {8'h00, 8'h81, 32'h0001_4004},
    {8'hFF, 8'h6E, 32'h0000_0120}
  };

  logic [7:0] mon_cm = '0, mon_dm = '0, prev_cm = '0;
  logic prev_cp = 1'b0;
  logic [7:0] cap = '0;
  int ncap = 0, side_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mon_cm == prev_cm) begin
        if ((|(port_out & mon_cm)) && !prev_cp) begin
          cap  <= {cap[6:0], |(port_out & mon_dm)};
          ncap <= ncap + 1;
        end
      end
      prev_cm <= mon_cm;
      prev_cp <= |(port_out & mon_cm);
      if ((port_out & ~(mon_cm | mon_dm)) != (shadow_in & ~(mon_cm | mon_dm)))
        side_bad <= side_bad + 1;
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [16:0] w, input logic ok, output logic err);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = w;
    @(posedge clk);
    #1;
    mon_cm = ok ? w[7:0] : 8'h00;
    mon_dm = ok ? w[15:8] : 8'h00;
    @(negedge clk);
    cfg_wr = 1'b0;
    err = cfg_err;
  endtask

  task automatic send(input logic [7:0] b, output int n, output logic werr);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    werr = wr_err;
    n = 1;
    while (!in_ready) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, n0;
    logic e, we;
    logic [7:0] exp_cap;

    shadow_in = 8'h3A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset in_ready", in_ready, 1);
    chk("R11 reset cfg_err", cfg_err, 0);
    chk("R11 reset wr_err", wr_err, 0);
    chk("R11 reset port equals shadow", port_out, 8'h3A);

    n0 = ncap;
    send(8'hFF, n, we);
    chk("R3 zero-mask wr_err pulse", we, 1);
    chk("R3 zero-mask byte consumed at once", n, 1);
    @(negedge clk);
    chk("R3 wr_err one cycle", wr_err, 0);
    chk("R3 no clock edge", ncap - n0, 0);

    for (int k = 0; k < 4; k++) begin
      shadow_in = VEC[k][47:40];
      do_cfg(VEC[k][16:0], 1'b1, e);
      chk("R1 config accepted", e, 0);
      n0 = ncap;
      send(VEC[k][39:32], n, we);
      exp_cap = VEC[k][16] ? VEC[k][39:32] : rev8(VEC[k][39:32]);
      chk("R5 bit order on pins", cap, exp_cap);
      chk("R4 eight clock rises", ncap - n0, 8);
      chk("R7 R4 ready after 8 periods", n, BYTE_CYC);
      chk("R8 clock pin high when idle", |(port_out & VEC[k][7:0]), 1);
    end

    wr_ok_mask = 8'hFE;
    do_cfg(17'h0_0201, 1'b0, e);
    chk("R2 refused, clock not writable", e, 1);
    chk("R2 port equals shadow after refusal", port_out, shadow_in);
    send(8'h12, n, we);
    chk("R3 write after refusal", we, 1);
    wr_ok_mask = 8'hFF;
    out_dir = 8'hFD;
    do_cfg(17'h0_0201, 1'b0, e);
    chk("R2 refused, data not output", e, 1);
    out_dir = 8'hFF;

    do_cfg(17'h1_0201, 1'b1, e);
    chk("R1 accept clears cfg_err", e, 0);
    n0 = ncap;
    fork
      send(8'hC3, n, we);
      begin
        repeat (6) @(negedge clk);
        cfg_wr = 1'b1; cfg_word = 17'h0_8040;
        @(negedge clk);
        cfg_wr = 1'b0;
      end
    join
    chk("R9 byte unaffected by busy config", cap, 8'hC3);
    send(8'h5A, n, we);
    chk("R9 old pins and order kept", cap, 8'h5A);
    chk("R9 sixteen rises on old clock pin", ncap - n0, 16);

    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = 17'h0_0408;
    in_valid = 1'b1; in_data = 8'hB1;
    #0.5;
    chk("R10 in_ready low with cfg_wr", in_ready, 0);
    @(posedge clk);
    #1;
    mon_cm = 8'h08; mon_dm = 8'h04;
    @(negedge clk);
    cfg_wr = 1'b0;
    n0 = ncap;
    in_valid = 1'b0;
    send(8'hB1, n, we);
    chk("R10 byte sent on new pins", cap, rev8(8'hB1));
    chk("R10 eight rises", ncap - n0, 8);

    chk("R6 unselected bits followed shadow", side_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule